// File: doc/BRIEF.md
# Camera Pixel Capture Interface

This block sits directly on the parallel output of a CMOS image sensor and runs only on the sensor's pixel clock. Each rising edge of that clock registers a vertical sync strobe, a horizontal reference strobe and two 8-bit sample channels, one carrying luma and one carrying chroma. A rising edge of the vertical sync opens a new frame. While the horizontal reference is active and the vertical sync is not, every clock edge yields one pixel.

Each pixel leaves the block as one merged word with a single-cycle valid strobe. The output is two clocks behind the edge that sampled the sensor pins. A mode pin selects raw RGB or YUV operation. In raw RGB mode the first active line of each frame carries no usable data, so the block discards it. The block also counts the pixels it emits in each frame. When the next frame starts, it loads that count into a held result register and gives a one-cycle done pulse. Moving the pixels into another clock domain and storing them is left to the logic that follows.

Top module: `cam_pixel_capture`

## Requirements
- R1: While rst_n is low, pix_valid and frame_done are 0 and frame_pixels is 0.
- R2: A clock edge at which href is active, vsync is inactive and a frame is open produces exactly one pix_valid pulse. That pulse is visible two rising edges after the edge that sampled the pins.
- R3: With default parameters, pix_data[15:8] holds the sampled y_in byte and pix_data[7:0] holds the sampled uv_in byte of the same edge.
- R4: No pixel is produced before the first vsync rising edge after reset, even if href is active.
- R5: With raw_rgb_mode = 1 for a frame, every pixel of the first line that has href active outside vsync is discarded. With raw_rgb_mode = 0, no line is discarded.
- R6: raw_rgb_mode is taken once, at the frame start. Changing it later in the frame has no effect until the next frame start.
- R7: At each vsync rising edge that closes an open frame, frame_done pulses for exactly one cycle, and frame_pixels loads the number of pix_valid pulses of that frame. The count then restarts from 0.
- R8: Between frame_done pulses, frame_pixels holds its value.
- R9: While vsync is active, href activity produces no pixel and does not count as the frame's first line.
- R10: The first vsync rising edge after reset opens a frame but gives no frame_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock, rising edge used |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_rgb_mode | input | 1 | 1 = raw RGB (first line dropped), 0 = YUV |
| vsync | input | 1 | Frame strobe from the sensor |
| href | input | 1 | Active-pixel window of a line |
| y_in | input | 8 | Luma channel |
| uv_in | input | 8 | Chroma channel |
| pix_data | output | 16 | Merged pixel word |
| pix_valid | output | 1 | One-cycle strobe per pixel |
| frame_done | output | 1 | One-cycle pulse when a frame closes |
| frame_pixels | output | 16 | Pixel count of the last closed frame |

## Verification
The assertions assume that vsync and href are synchronous to clk and are held at 0 during reset. This lets the two-cycle look-back on the pins refer only to sampled, defined values. The stimulus changes every input only on the falling clock edge. It keeps href pulses that overlap vsync wholly inside the vsync window, and it holds raw_rgb_mode steady for at least three cycles after each vsync rise. Random frames vary line count, line width, gaps, vsync length and mode. Directed frames cover pre-frame lines, mid-frame mode changes and href activity inside vsync.

// File: rtl/cap_pkg.sv
package cap_pkg;
   // Sampled, polarity-normalised sensor strobes
   typedef struct packed {
      logic vs;       // vertical sync active
      logic vs_rise;  // first edge of vertical sync
      logic href;     // line window active
   } cap_strobe_t;
endpackage

// File: rtl/cap_sync_stage.sv
module cap_sync_stage
   import cap_pkg::*;
#(
   parameter int CH_W     = 8,
   parameter bit VS_POL   = 1'b1,
   parameter bit HREF_POL = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vsync,
   input  logic            href,
   input  logic [CH_W-1:0] y_in,
   input  logic [CH_W-1:0] uv_in,
   output cap_strobe_t     st,
   output logic [CH_W-1:0] y_q,
   output logic [CH_W-1:0] uv_q
);
   logic vs_act, hr_act;
   logic vs_q, vs_qq, hr_q;

   generate
      if (VS_POL) begin : g_vs_hi
         assign vs_act = vsync;
      end else begin : g_vs_lo
         assign vs_act = ~vsync;
      end
      if (HREF_POL) begin : g_hr_hi
         assign hr_act = href;
      end else begin : g_hr_lo
         assign hr_act = ~href;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vs_q  <= 1'b0;
         vs_qq <= 1'b0;
         hr_q  <= 1'b0;
         y_q   <= '0;
         uv_q  <= '0;
      end else begin
         vs_q  <= vs_act;
         vs_qq <= vs_q;
         hr_q  <= hr_act;
         y_q   <= y_in;
         uv_q  <= uv_in;
      end
   end

   assign st.vs      = vs_q;
   assign st.vs_rise = vs_q & ~vs_qq;
   assign st.href    = hr_q;
endmodule

// File: rtl/cap_line_gate.sv
module cap_line_gate
   import cap_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  cap_strobe_t st,
   input  logic        raw_rgb_mode,
   output logic        accept,
   output logic        frame_open
);
   logic mode_raw, first_line, line_hit;
   logic in_window;

   assign in_window = frame_open & st.href & ~st.vs;
   assign accept    = in_window & ~(mode_raw & first_line);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_open <= 1'b0;
         mode_raw   <= 1'b0;
         first_line <= 1'b0;
         line_hit   <= 1'b0;
      end else if (st.vs_rise) begin
         frame_open <= 1'b1;
         mode_raw   <= raw_rgb_mode;
         first_line <= 1'b1;
         line_hit   <= 1'b0;
      end else if (in_window) begin
         line_hit   <= 1'b1;
      end else if (line_hit && !st.href) begin
         first_line <= 1'b0;
         line_hit   <= 1'b0;
      end
   end
endmodule

// File: rtl/cap_pixel_pack.sv
module cap_pixel_pack #(
   parameter int CH_W    = 8,
   parameter bit Y_UPPER = 1'b1,
   localparam int OUT_W  = 2 * CH_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [CH_W-1:0]  y_q,
   input  logic [CH_W-1:0]  uv_q,
   output logic [OUT_W-1:0] pix_data,
   output logic             pix_valid
);
   logic [OUT_W-1:0] merged;

   generate
      if (Y_UPPER) begin : g_y_hi
         assign merged = {y_q, uv_q};
      end else begin : g_y_lo
         assign merged = {uv_q, y_q};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_data  <= '0;
         pix_valid <= 1'b0;
      end else begin
         pix_valid <= accept;
         if (accept) pix_data <= merged;
      end
   end
endmodule

// File: rtl/cap_frame_counter.sv
module cap_frame_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             frame_start,
   input  logic             frame_open,
   output logic             frame_done,
   output logic [CNT_W-1:0] frame_pixels
);
   logic [CNT_W-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt      <= '0;
         frame_done   <= 1'b0;
         frame_pixels <= '0;
      end else begin
         frame_done <= 1'b0;
         if (frame_start) begin
            if (frame_open) begin
               frame_done   <= 1'b1;
               frame_pixels <= run_cnt;
            end
            run_cnt <= '0;
         end else if (accept) begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cam_pixel_capture.sv
module cam_pixel_capture
   import cap_pkg::*;
#(
   parameter int CH_W     = 8,
   parameter int CNT_W    = 16,
   parameter bit VS_POL   = 1'b1,
   parameter bit HREF_POL = 1'b1,
   parameter bit Y_UPPER  = 1'b1,
   localparam int OUT_W   = 2 * CH_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_rgb_mode,
   input  logic             vsync,
   input  logic             href,
   input  logic [CH_W-1:0]  y_in,
   input  logic [CH_W-1:0]  uv_in,
   output logic [OUT_W-1:0] pix_data,
   output logic             pix_valid,
   output logic             frame_done,
   output logic [CNT_W-1:0] frame_pixels
);
   generate
      if (CH_W < 1) begin : g_bad_ch
         $error("cam_pixel_capture: CH_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("cam_pixel_capture: CNT_W must be at least 2");
      end
   endgenerate

   cap_strobe_t     st;
   logic [CH_W-1:0] y_q, uv_q;
   logic            accept, frame_open;

   cap_sync_stage #(
      .CH_W(CH_W), .VS_POL(VS_POL), .HREF_POL(HREF_POL)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .href(href),
      .y_in(y_in), .uv_in(uv_in), .st(st), .y_q(y_q), .uv_q(uv_q)
   );

   cap_line_gate u_gate (
      .clk(clk), .rst_n(rst_n), .st(st), .raw_rgb_mode(raw_rgb_mode),
      .accept(accept), .frame_open(frame_open)
   );

   cap_pixel_pack #(
      .CH_W(CH_W), .Y_UPPER(Y_UPPER)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .accept(accept), .y_q(y_q), .uv_q(uv_q),
      .pix_data(pix_data), .pix_valid(pix_valid)
   );

   cap_frame_counter #(
      .CNT_W(CNT_W)
   ) u_count (
      .clk(clk), .rst_n(rst_n), .accept(accept), .frame_start(st.vs_rise),
      .frame_open(frame_open), .frame_done(frame_done),
      .frame_pixels(frame_pixels)
   );
endmodule

// File: rtl/cam_capture_checker.sv
module cam_capture_checker #(
   parameter int CH_W     = 8,
   parameter int CNT_W    = 16,
   parameter bit VS_POL   = 1'b1,
   parameter bit HREF_POL = 1'b1,
   parameter bit Y_UPPER  = 1'b1,
   localparam int OUT_W   = 2 * CH_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vsync,
   input logic             href,
   input logic [CH_W-1:0]  y_in,
   input logic [CH_W-1:0]  uv_in,
   input logic [OUT_W-1:0] pix_data,
   input logic             pix_valid,
   input logic             frame_done,
   input logic [CNT_W-1:0] frame_pixels
);
   logic vs_act, hr_act;
   assign vs_act = (vsync == VS_POL);
   assign hr_act = (href == HREF_POL);

   // R2: a pixel needs href active at the sampling edge
   p_valid_href_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> $past(hr_act, 2));

   // R3: byte placement of the two channels
   p_data_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (pix_data == (Y_UPPER ? {$past(y_in, 2), $past(uv_in, 2)}
                                          : {$past(uv_in, 2), $past(y_in, 2)})));

   // R9: nothing emitted from a vsync-active edge
   p_no_pix_vsync_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> !$past(vs_act, 2));

   // R7: done lasts one cycle
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R7: done only follows a vsync rise
   p_done_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> ($past(vs_act, 2) && !$past(vs_act, 3)));

   // R8: result register holds between pulses
   p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |-> $stable(frame_pixels));
endmodule

bind cam_pixel_capture cam_capture_checker #(
   .CH_W(CH_W), .CNT_W(CNT_W), .VS_POL(VS_POL),
   .HREF_POL(HREF_POL), .Y_UPPER(Y_UPPER)
) u_chk (
   .clk(clk), .rst_n(rst_n), .vsync(vsync), .href(href),
   .y_in(y_in), .uv_in(uv_in), .pix_data(pix_data),
   .pix_valid(pix_valid), .frame_done(frame_done),
   .frame_pixels(frame_pixels)
);

// File: tb/cam_pixel_capture_test.sv
module cam_pixel_capture_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        raw_rgb_mode = 1'b0;
   logic        vsync = 1'b0;
   logic        href = 1'b0;
   logic [7:0]  y_in = '0;
   logic [7:0]  uv_in = '0;
   logic [15:0] pix_data;
   logic        pix_valid;
   logic        frame_done;
   logic [15:0] frame_pixels;

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_pix[$];
   int          exp_cnt[$];
   bit in_frame_tb = 0, mode_tb = 0, first_line_tb = 0;
   int cur_cnt = 0, last_exp = 0;

   always #4 clk = ~clk;

   cam_pixel_capture uut (
      .clk(clk), .rst_n(rst_n), .raw_rgb_mode(raw_rgb_mode),
      .vsync(vsync), .href(href), .y_in(y_in), .uv_in(uv_in),
      .pix_data(pix_data), .pix_valid(pix_valid),
      .frame_done(frame_done), .frame_pixels(frame_pixels)
   );

   function automatic logic [15:0] merge(input logic [7:0] y, input logic [7:0] uv);
      return {y, uv};  // R3: luma high byte, chroma low byte
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Output monitor: pixel order and frame counts
   always @(negedge clk) begin
      if (rst_n) begin
         if (pix_valid) begin
            if (exp_pix.size() == 0)
               check(0, "R4/R9 unexpected pixel", int'(pix_data), 0);
            else begin
               logic [15:0] e;
               e = exp_pix.pop_front();
               check(pix_data == e, "R3 pixel word (R2/R5/R6 order)", int'(pix_data), int'(e));
            end
         end
         if (frame_done) begin
            if (exp_cnt.size() == 0)
               check(0, "R10 done without open frame", int'(frame_pixels), 0);
            else begin
               int e;
               e = exp_cnt.pop_front();
               check(int'(frame_pixels) == e, "R7 frame pixel count", int'(frame_pixels), e);
            end
         end
      end
   end

   task automatic start_frame(input int vs_len, input bit href_inside);
      check(int'(frame_pixels) == last_exp, "R8 held count", int'(frame_pixels), last_exp);
      if (in_frame_tb) begin
         exp_cnt.push_back(cur_cnt);
         last_exp = cur_cnt;
      end
      cur_cnt = 0;
      in_frame_tb = 1;
      mode_tb = raw_rgb_mode;  // R6: mode taken at frame start
      first_line_tb = 1;
      vsync = 1'b1;
      for (int i = 0; i < vs_len; i++) begin
         // R9: href pulse wholly inside vsync, never a pixel or first line
         href = href_inside && (i >= 1) && (i < vs_len - 1);
         y_in = 8'($urandom);
         uv_in = 8'($urandom);
         tick();
      end
      href = 1'b0;
      vsync = 1'b0;
      tick();
   endtask

   task automatic line(input int w, input int gap, input int flip_at, input bit flip_val);
      bool_keep: begin end
      for (int i = 0; i < w; i++) begin
         if (i == flip_at) raw_rgb_mode = flip_val;
         href = 1'b1;
         y_in = 8'($urandom);
         uv_in = 8'($urandom);
         // R5: drop first line only for raw frames
         if (in_frame_tb && !(mode_tb && first_line_tb)) begin
            exp_pix.push_back(merge(y_in, uv_in));
            cur_cnt++;
         end
         tick();
      end
      href = 1'b0;
      y_in = '0;
      uv_in = '0;
      if (in_frame_tb) first_line_tb = 0;
      for (int g = 0; g < gap; g++) tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0135));
      repeat (3) tick();
      // R1: reset state
      check(pix_valid == 0, "R1 pix_valid", int'(pix_valid), 0);
      check(frame_done == 0, "R1 frame_done", int'(frame_done), 0);
      check(frame_pixels == 0, "R1 frame_pixels", int'(frame_pixels), 0);
      rst_n = 1'b1;
      tick();

      // R4: lines before any frame start
      line(6, 2, -1, 0);
      line(4, 3, -1, 0);

      // R10: first frame start, YUV, no drop
      raw_rgb_mode = 0;
      start_frame(4, 0);
      line(5, 2, -1, 0);
      line(7, 1, -1, 0);
      line(3, 3, -1, 0);

      // R5: raw frame drops first line
      raw_rgb_mode = 1;
      start_frame(3, 0);
      line(6, 2, -1, 0);
      line(6, 2, -1, 0);
      line(4, 2, -1, 0);

      // R6: raw at start, cleared mid first line: drop still applies
      start_frame(3, 0);
      line(8, 2, 2, 0);
      line(5, 2, -1, 0);

      // R6: YUV at start, set raw before first line: no drop
      start_frame(5, 0);
      raw_rgb_mode = 1;
      line(4, 2, -1, 0);
      line(4, 2, -1, 0);

      // R9: href inside vsync, raw frame, first real line still dropped
      start_frame(6, 1);
      line(5, 2, -1, 0);
      line(5, 2, -1, 0);

      // Random frames
      for (int f = 0; f < 8; f++) begin
         raw_rgb_mode = 1'($urandom);
         start_frame(3 + int'($urandom % 4), 1'($urandom));
         for (int l = 0, n = 1 + int'($urandom % 4); l < n; l++)
            line(1 + int'($urandom % 16), 1 + int'($urandom % 4), -1, 0);
      end

      start_frame(3, 0);
      repeat (6) tick();
      check(exp_pix.size() == 0, "R2/R5 pixels missing", exp_pix.size(), 0);
      check(exp_cnt.size() == 0, "R7 done pulses missing", exp_cnt.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule